// File: doc/BRIEF.md
# Four-Pin General-Purpose I/O Port Slice

This block is one narrow I/O port of a microcontroller's peripheral set. Three of its pins can drive or read. The fourth pin is input-only. Software uses a small register window to set each bidirectional pin as an output or an input, to hold the value that the pin drives, and to read the synchronised pin levels. The I/O pad takes a driver enable and a data value for each bidirectional pin.

Each bidirectional pin has its own analog-select line, which comes from the converter's configuration logic. A selected pin reads back as zero at the pin-state address. The direction bit still controls that pin's output driver, so software must keep an analog pin set as an input. A strap input decides whether the input-only pin is a digital input or the device reset. When it is the device reset, its bit reads zero. A build parameter selects a reduced package, in which only the input-only pin exists.

The bus is a single-cycle register interface with a 2-bit address:
- 0 selects the pin-state register.
- 1 selects the output latch.
- 2 selects the direction register.
- 3 is unused.

Reads are combinational. Writes take effect at the clock edge on which `bus_wr` is high.

The converter logic that owns `ana_sel` must hold it at all ones after power-on reset. The three bidirectional pins then start as analog inputs.

Top module: `gpio4_port`

## Requirements
- R1: Direction bit i = 1 turns off pad driver i (`pad_oe[i]` = 0). Direction bit i = 0 enables the driver (`pad_oe[i]` = 1), and `pad_out[i]` carries latch bit i. Address 2 reads the direction bits on rdata[2:0].
- R2: With `ana_sel[i]` = 1, bit i at address 0 reads 0. `pad_oe[i]` and `pad_out[i]` are unaffected.
- R3: Address 1 reads the three latch bits on rdata[2:0], whatever the pin levels are.
- R4: A write to address 0 or to address 1 loads bus_wdata[2:0] into the latch. Other data bits have no effect.
- R5: Bit 3 at address 0 returns the synchronised level of `pad_in[3]` when `rst_strap` = 0. It returns 0 when `rst_strap` = 1.
- R6: rdata[7:4] at address 0 is always 0. At addresses 1 and 2, rdata[7:3] is always 0. Address 3 always reads 0, and a write to address 3 changes nothing.
- R7: While reset is asserted, and after it is released, the direction register holds 3'b111 and the latch holds 3'b000. Reset assertion is asynchronous. Release is synchronised over two clock edges, and writes are ignored until release completes.
- R8: A change on `pad_in` shows at address 0 after two rising clock edges.
- R9: With `FULL_PKG` = 0, `pad_oe` and `pad_out` stay 0. Bits 2..0 read 0 at every address. Only bit 3 at address 0 follows R5.
- R10: A register write is visible on rdata, `pad_oe` and `pad_out` right after the edge on which `bus_wr` was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register select: 0 pin state, 1 latch, 2 direction, 3 unused |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ana_sel | input | 3 | Analog select per bidirectional pin |
| rst_strap | input | 1 | 1: fourth pin is the reset input; 0: digital input |
| pad_in | input | 4 | Raw pin levels from the pads |
| pad_out | output | 3 | Output data to the bidirectional pads |
| pad_oe | output | 3 | Driver enable per bidirectional pad, 1 = drive |

## Verification
A wrong latch or direction bit shows up on `pad_out` or `pad_oe` in the very next cycle after the faulty edge. It also shows up on rdata whenever address 1 or 2 is selected, so a reference model compared every cycle catches it at once. A wrong synchroniser depth or bit order changes the delay from pin to read, and a pin pattern that toggles exposes it within two cycles. Errors in the analog-select or strap masking appear only on pin-state reads taken while those inputs are set. For that reason the stimulus reads address 0 under every combination of analog select and strap.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int DATA_W  = 8;
  localparam int BIDIR_N = 3;

  typedef enum logic [1:0] {
    REG_PIN  = 2'd0,
    REG_LAT  = 2'd1,
    REG_DIR  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio4_rst_sync.sv
module gpio4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];

  // R7: release only follows a clock with the raw reset already high
  p_release_sync_r7: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_n_o) |-> $past(arst_n));
endmodule

// File: rtl/gpio4_in_sync.sv
module gpio4_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] age_q;
    logic [1:0] age_d;
    logic       age_en;
    always_comb begin
      age_en = (age_q != 2'd2);
      age_d  = age_q + 2'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      age_q <= '0;
      else if (age_en) age_q <= age_d;
    end
    // R8: pin level visible two edges later
    p_two_edge_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q == 2'd2) |-> (dout == $past(din, 2)));
  end
endmodule

// File: rtl/gpio4_ctl_regs.sv
module gpio4_ctl_regs
  import gpio4_pkg::*;
#(
  parameter int NB = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  reg_sel_e      sel,
  input  logic [NB-1:0] wdata,
  output logic [NB-1:0] lat_q,
  output logic [NB-1:0] dir_q
);
  logic          lat_en, dir_en;
  logic [NB-1:0] lat_d, dir_d;

  always_comb begin
    lat_en = wr && ((sel == REG_PIN) || (sel == REG_LAT));
    dir_en = wr && (sel == REG_DIR);
    lat_d  = wdata;
    dir_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '1;
    else if (dir_en) dir_q <= dir_d;
  end

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (sel == REG_PIN || sel == REG_LAT)) |=> $stable(lat_q));
  p_dir_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == REG_DIR) |=> (dir_q == $past(wdata)));
  p_dir_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == REG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio4_rd_mux.sv
module gpio4_rd_mux
  import gpio4_pkg::*;
#(
  parameter int NB   = 3,
  parameter int DW   = 8,
  parameter bit FULL = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  reg_sel_e      sel,
  input  logic [NB:0]   pin_q,
  input  logic [NB-1:0] ana_sel,
  input  logic          strap,
  input  logic [NB-1:0] lat_q,
  input  logic [NB-1:0] dir_q,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    unique case (sel)
      REG_PIN: begin
        for (int i = 0; i < NB; i++) rd_d[i] = FULL && !ana_sel[i] && pin_q[i];
        rd_d[NB] = !strap && pin_q[NB];
      end
      REG_LAT: if (FULL) rd_d[NB-1:0] = lat_q;
      REG_DIR: if (FULL) rd_d[NB-1:0] = dir_q;
      default: rd_d = '0;
    endcase
  end

  assign rdata = rd_d;

  p_analog_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_PIN) |-> ((rdata[NB-1:0] & ana_sel) == '0));
  p_strap_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_PIN && strap) |-> !rdata[NB]);
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[DW-1:NB+1] == '0) && ((sel == REG_NONE) -> (rdata == '0)));
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
#(
  parameter bit FULL_PKG    = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int NB          = BIDIR_N,
  parameter int DW          = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NB-1:0] ana_sel,
  input  logic          rst_strap,
  input  logic [NB:0]   pad_in,
  output logic [NB-1:0] pad_out,
  output logic [NB-1:0] pad_oe
);
  localparam int PW = NB + 1;

  logic          rst_int_n;
  reg_sel_e      sel;
  logic [PW-1:0] pin_q;
  logic [NB-1:0] lat_q, dir_q;
  logic          unused_wdata;

  assign sel          = reg_sel_e'(bus_addr);
  assign unused_wdata = ^bus_wdata[DW-1:NB];

  gpio4_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_int_n)
  );

  gpio4_in_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(pad_in), .dout(pin_q)
  );

  if (FULL_PKG) begin : g_full
    gpio4_ctl_regs #(.NB(NB)) u_regs (
      .clk(clk), .rst_n(rst_int_n), .wr(bus_wr), .sel(sel),
      .wdata(bus_wdata[NB-1:0]), .lat_q(lat_q), .dir_q(dir_q)
    );
    assign pad_oe  = ~dir_q;
    assign pad_out = lat_q;

    // R10: a write through the pin-state address reaches the pads next cycle
    p_port_write_pad_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
      (bus_wr && sel == REG_PIN) |=> (pad_out == $past(bus_wdata[NB-1:0])));
    // R2: analog select changes never move the drivers
    p_analog_keeps_drive_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
      (!bus_wr && $past(!bus_wr)) |-> $stable(pad_oe));
  end else begin : g_reduced
    assign lat_q   = '0;
    assign dir_q   = '1;
    assign pad_oe  = '0;
    assign pad_out = '0;
  end

  gpio4_rd_mux #(.NB(NB), .DW(DW), .FULL(FULL_PKG)) u_rd (
    .clk(clk), .rst_n(rst_int_n), .sel(sel), .pin_q(pin_q),
    .ana_sel(ana_sel), .strap(rst_strap), .lat_q(lat_q), .dir_q(dir_q),
    .rdata(bus_rdata)
  );
endmodule

// File: tb/gpio4_port_tb.sv
module gpio4_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [2:0] ana_sel = 3'b111;
  logic       rst_strap = 1'b0;
  logic [3:0] pad_in = 4'd0;
  logic [7:0] bus_rdata, rp_rdata;
  logic [2:0] pad_out, pad_oe, rp_out, rp_oe;

  int vectors = 0;
  int miscompares = 0;

  // behavioural model state
  logic [2:0] lat_m, dir_m;
  logic [3:0] q1, q2;
  int         rcnt;

  always #5ns clk = ~clk;

  gpio4_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ana_sel(ana_sel),
    .rst_strap(rst_strap), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio4_port #(.FULL_PKG(1'b0)) dut_rp_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rp_rdata), .ana_sel(ana_sel),
    .rst_strap(rst_strap), .pad_in(pad_in), .pad_out(rp_out), .pad_oe(rp_oe)
  );

  task automatic model_reset();
    lat_m = 3'b000; dir_m = 3'b111; q1 = '0; q2 = '0; rcnt = 0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    logic [7:0] r = 8'h00;
    case (a)
      2'd0: begin
        for (int i = 0; i < 3; i++) r[i] = q2[i] & ~ana_sel[i];
        r[3] = q2[3] & ~rst_strap;
      end
      2'd1: r[2:0] = lat_m;
      2'd2: r[2:0] = dir_m;
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  // one cycle: drive at negedge, compare before the rising edge, then advance the model
  task automatic step(input string tag, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd, input logic [2:0] an,
                      input logic st, input logic [3:0] pin);
    @(negedge clk);
    bus_wr = wr; bus_addr = a; bus_wdata = wd; ana_sel = an; rst_strap = st; pad_in = pin;
    if (!rst_n) model_reset();
    #4ns;
    chk({tag, " rdata"}, bus_rdata, exp_rd(a));
    chk({tag, " R1 pad_oe"}, {5'd0, pad_oe}, {5'd0, ~dir_m});
    chk({tag, " R1 pad_out"}, {5'd0, pad_out}, {5'd0, lat_m});
    chk("R9 reduced rdata", rp_rdata, {4'd0, (a == 2'd0) && q2[3] && !st, 3'd0});
    chk("R9 reduced drive", {2'd0, rp_oe, rp_out}, 8'd0);
    @(posedge clk);
    if (!rst_n) model_reset();
    else if (rcnt < 2) begin
      model_reset_hold();
    end else begin
      q2 = q1; q1 = pin;
      if (wr && (a == 2'd0 || a == 2'd1)) lat_m = wd[2:0];
      if (wr && a == 2'd2) dir_m = wd[2:0];
    end
  endtask

  task automatic model_reset_hold();
    int keep = rcnt;
    model_reset();
    rcnt = keep + 1;
  endtask

  function automatic string tag_of(input logic [1:0] a);
    case (a)
      2'd0: return "R8";
      2'd1: return "R3";
      2'd2: return "R1";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #2ms;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    model_reset();
    // R7: reset state while held and right after release; early write ignored
    step("R7", 1'b0, 2'd2, 8'h00, 3'b111, 1'b0, 4'h0);
    step("R7", 1'b0, 2'd1, 8'h00, 3'b111, 1'b0, 4'h0);
    @(negedge clk); rst_n = 1'b1;
    step("R7", 1'b1, 2'd2, 8'h00, 3'b111, 1'b0, 4'h0);
    step("R7", 1'b0, 2'd2, 8'h00, 3'b111, 1'b0, 4'h0);
    step("R7", 1'b0, 2'd1, 8'h00, 3'b111, 1'b0, 4'h0);
    // R8: pin pattern seen after two edges
    for (int k = 0; k < 4; k++) step("R8", 1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 4'b1010);
    for (int k = 0; k < 3; k++) step("R8", 1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 4'b0101);
    // R4: port and latch addresses both load the latch; upper bits ignored
    step("R4", 1'b1, 2'd0, 8'hFD, 3'b000, 1'b0, 4'b0101);
    step("R4", 1'b0, 2'd1, 8'h00, 3'b000, 1'b0, 4'b0101);
    step("R4", 1'b1, 2'd1, 8'hF2, 3'b000, 1'b0, 4'b0101);
    step("R4", 1'b0, 2'd1, 8'h00, 3'b000, 1'b0, 4'b0101);
    // R6: unused address write changes nothing and reads zero
    step("R6", 1'b1, 2'd3, 8'hFF, 3'b000, 1'b0, 4'b1111);
    step("R6", 1'b0, 2'd3, 8'h00, 3'b000, 1'b0, 4'b1111);
    step("R6", 1'b0, 2'd1, 8'h00, 3'b000, 1'b0, 4'b1111);
    // R10 / R1: direction write drives pads on the next cycle
    step("R10", 1'b1, 2'd2, 8'hF8, 3'b000, 1'b0, 4'b1111);
    step("R10", 1'b0, 2'd2, 8'h00, 3'b000, 1'b0, 4'b1111);
    // R3: latch readback differs from pin levels
    step("R3", 1'b0, 2'd1, 8'h00, 3'b000, 1'b0, 4'b1101);
    step("R3", 1'b0, 2'd1, 8'h00, 3'b000, 1'b0, 4'b1101);
    // R2: analog selected pins read zero, drivers unchanged
    for (int k = 0; k < 3; k++) step("R2", 1'b0, 2'd0, 8'h00, 3'b111, 1'b0, 4'b1111);
    step("R2", 1'b0, 2'd0, 8'h00, 3'b010, 1'b0, 4'b1111);
    // R5: strap masks the input-only pin
    for (int k = 0; k < 3; k++) step("R5", 1'b0, 2'd0, 8'h00, 3'b000, 1'b1, 4'b1111);
    step("R5", 1'b0, 2'd0, 8'h00, 3'b000, 1'b0, 4'b1111);
    // mixed traffic
    for (int k = 0; k < 400; k++) begin
      logic [1:0] a = 2'($urandom_range(0, 3));
      step(tag_of(a), 1'($urandom_range(0, 1)), a, 8'($urandom),
           3'($urandom), 1'($urandom_range(0, 1)), 4'($urandom));
    end
    // R7: asynchronous reset mid-run
    @(negedge clk); rst_n = 1'b0;
    step("R7", 1'b0, 2'd2, 8'h00, 3'b111, 1'b0, 4'hF);
    @(negedge clk); rst_n = 1'b1;
    step("R7", 1'b1, 2'd1, 8'h07, 3'b111, 1'b0, 4'hF);
    for (int k = 0; k < 3; k++) step("R7", 1'b0, 2'd1, 8'h00, 3'b111, 1'b0, 4'hF);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule